// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a small accumulator machine. Instructions and data share one memory of 16-bit words. Every word has the same layout: a 4-bit operation code on top and a 12-bit direct address below it. The machine runs a fixed cycle. It fetches a word into the instruction register, decodes it, and executes it. It can then take an interrupt cycle before it fetches the next instruction. All memory traffic passes through two registers, a memory address register and a memory buffer register. The memory port shows those two registers directly, together with a write strobe. Read data comes back one clock after the address is presented.

Three operations are supported: load the accumulator, store the accumulator, and add a memory word to the accumulator. Every other code stops the machine. When the interrupt request is high at the end of an execute phase, the machine does three things before the next fetch. It writes the address of the next instruction to a fixed save location, pulses an acknowledge, and continues fetching from a vector address. The start, vector and save addresses are parameters.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is asserted, the accumulator, instruction, address and buffer registers are zero, so `memAddr` reads 0 and `memWe`, `irqAck` and `halted` are low. One clock after reset is released, `memAddr` equals the start-address parameter.
- R2: Instructions are fetched from consecutive addresses. After each fetch the program counter has advanced by one, so the next instruction comes from the following word.
- R3: Code 4'b0001 in bits 15:12 loads the accumulator with the word at the address in bits 11:0. This replaces the previous accumulator value.
- R4: Code 4'b0010 drives the address in bits 11:0 on `memAddr` and the accumulator on `memWrData`, with `memWe` high for exactly one cycle.
- R5: Code 4'b0101 adds the addressed word to the accumulator modulo 2^16. No carry is kept.
- R6: Any other code (including 4'b0000) sets `halted`. After that, `halted` stays high, no write occurs, no acknowledge occurs and `memAddr` does not change until reset.
- R7: If `irqReq` is high at the end of an execute phase, the next two cycles set up and perform a write of the next instruction's address to the save-address parameter. `irqAck` is high only in that write cycle. Fetching then continues from the vector parameter.
- R8: `irqReq` is acted on only at the end of an execute phase. It has no effect while the machine is halted.
- R9: `memWe` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memRdData | input | 16 | Word read from memory, valid one cycle after its address |
| irqReq | input | 1 | Interrupt request level |
| memAddr | output | 12 | Memory address (address register) |
| memWrData | output | 16 | Memory write data (buffer register) |
| memWe | output | 1 | Memory write strobe |
| irqAck | output | 1 | One-cycle interrupt acknowledge, coincides with the save write |
| halted | output | 1 | High once an unlisted code has been decoded |

## Verification
A store's write and the entry into an interrupt cycle can fall in the same cycle. This happens when the request is sampled in the very cycle in which the store strobe is high. The bench raises `irqReq` at the falling edge where it first sees the store strobe. It then checks three results: the stored word landed, the saved return address is the word after the store, and the vector routine ran. A second coincidence is an add that wraps past 2^16. Its result is judged from a later store of the accumulator.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 4'b0001,
    OP_STORE = 4'b0010,
    OP_ADD   = 4'b0101
  } opcode_e;

  typedef enum logic [3:0] {
    S_F_ADDR,
    S_F_WAIT,
    S_F_MBR,
    S_F_IR,
    S_X_DEC,
    S_X_WAIT,
    S_X_MBR,
    S_X_ACC,
    S_X_WR,
    S_I_SAVE,
    S_I_WR,
    S_HALT
  } seq_state_e;

  // Register-transfer strobes from control to datapath.
  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic marFromSave;
    logic mbrFromMem;
    logic mbrFromAc;
    logic mbrFromPc;
    logic irFromMbr;
    logic pcInc;
    logic pcFromVector;
    logic acFromMbr;
    logic acAddMbr;
    logic memWe;
  } ctrl_t;

endpackage

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] START_ADDR = '0,
  parameter logic [ADDR_W-1:0] IRQ_VECTOR = '0,
  parameter logic [ADDR_W-1:0] SAVE_ADDR  = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctrl,
  input  logic [OP_W+ADDR_W-1:0]   memRdData,
  output logic [OP_W-1:0]          opcode,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [OP_W+ADDR_W-1:0]   memWrData
);

  localparam int DATA_W = OP_W + ADDR_W;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] mbrQ;
  logic [DATA_W-1:0] irQ;
  logic [DATA_W-1:0] acQ;

  logic [ADDR_W-1:0] irAddr;
  logic [DATA_W-1:0] pcWide;

  assign irAddr = irQ[ADDR_W-1:0];
  assign opcode = irQ[DATA_W-1:ADDR_W];
  assign pcWide = {{OP_W{1'b0}}, pcQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= START_ADDR;
    end else if (ctrl.pcFromVector) begin
      pcQ <= IRQ_VECTOR;
    end else if (ctrl.pcInc) begin
      pcQ <= pcQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      marQ <= '0;
    end else if (ctrl.marFromPc) begin
      marQ <= pcQ;
    end else if (ctrl.marFromIr) begin
      marQ <= irAddr;
    end else if (ctrl.marFromSave) begin
      marQ <= SAVE_ADDR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mbrQ <= '0;
    end else if (ctrl.mbrFromMem) begin
      mbrQ <= memRdData;
    end else if (ctrl.mbrFromAc) begin
      mbrQ <= acQ;
    end else if (ctrl.mbrFromPc) begin
      mbrQ <= pcWide;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irQ <= '0;
    end else if (ctrl.irFromMbr) begin
      irQ <= mbrQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acQ <= '0;
    end else if (ctrl.acFromMbr) begin
      acQ <= mbrQ;
    end else if (ctrl.acAddMbr) begin
      acQ <= acQ + mbrQ;
    end
  end

  assign memAddr   = marQ;
  assign memWrData = mbrQ;

endmodule

// File: rtl/acc_seq_control.sv
module acc_seq_control
  import acc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            irqReq,
  output ctrl_t           ctrl,
  output logic            irqAck,
  output logic            halted
);

  seq_state_e stateQ;
  seq_state_e stateD;

  logic isLoad;
  logic isStore;
  logic isAdd;

  assign isLoad  = (opcode == OP_LOAD);
  assign isStore = (opcode == OP_STORE);
  assign isAdd   = (opcode == OP_ADD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_F_ADDR;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    ctrl   = '0;
    stateD = stateQ;
    unique case (stateQ)
      S_F_ADDR: begin
        ctrl.marFromPc = 1'b1;
        stateD = S_F_WAIT;
      end
      S_F_WAIT: begin
        ctrl.pcInc = 1'b1;
        stateD = S_F_MBR;
      end
      S_F_MBR: begin
        ctrl.mbrFromMem = 1'b1;
        stateD = S_F_IR;
      end
      S_F_IR: begin
        ctrl.irFromMbr = 1'b1;
        stateD = S_X_DEC;
      end
      S_X_DEC: begin
        if (isLoad || isAdd) begin
          ctrl.marFromIr = 1'b1;
          stateD = S_X_WAIT;
        end else if (isStore) begin
          ctrl.marFromIr = 1'b1;
          ctrl.mbrFromAc = 1'b1;
          stateD = S_X_WR;
        end else begin
          stateD = S_HALT;
        end
      end
      S_X_WAIT: begin
        stateD = S_X_MBR;
      end
      S_X_MBR: begin
        ctrl.mbrFromMem = 1'b1;
        stateD = S_X_ACC;
      end
      S_X_ACC: begin
        ctrl.acFromMbr = isLoad;
        ctrl.acAddMbr  = isAdd;
        stateD = irqReq ? S_I_SAVE : S_F_ADDR;
      end
      S_X_WR: begin
        ctrl.memWe = 1'b1;
        stateD = irqReq ? S_I_SAVE : S_F_ADDR;
      end
      S_I_SAVE: begin
        ctrl.marFromSave = 1'b1;
        ctrl.mbrFromPc   = 1'b1;
        stateD = S_I_WR;
      end
      S_I_WR: begin
        ctrl.memWe        = 1'b1;
        ctrl.pcFromVector = 1'b1;
        stateD = S_F_ADDR;
      end
      S_HALT: begin
        stateD = S_HALT;
      end
      default: begin
        stateD = S_HALT;
      end
    endcase
  end

  assign irqAck = (stateQ == S_I_WR);
  assign halted = (stateQ == S_HALT);

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h010,
  parameter logic [ADDR_W-1:0] IRQ_VECTOR = 12'h200,
  parameter logic [ADDR_W-1:0] SAVE_ADDR  = 12'h0FF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [OP_W+ADDR_W-1:0]  memRdData,
  input  logic                    irqReq,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [OP_W+ADDR_W-1:0]  memWrData,
  output logic                    memWe,
  output logic                    irqAck,
  output logic                    halted
);

  ctrl_t           ctrl;
  logic [OP_W-1:0] opcode;

  acc_seq_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .irqReq (irqReq),
    .ctrl   (ctrl),
    .irqAck (irqAck),
    .halted (halted)
  );

  acc_seq_datapath #(
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR),
    .IRQ_VECTOR (IRQ_VECTOR),
    .SAVE_ADDR  (SAVE_ADDR)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .memRdData (memRdData),
    .opcode    (opcode),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

  assign memWe = ctrl.memWe;

endmodule

// File: rtl/acc_seq_checker.sv
module acc_seq_checker #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic              irqAck,
  input logic              irqReq,
  input logic              halted,
  input logic [ADDR_W-1:0] memAddr
);

  p_we_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  p_ack_is_save_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> (memWe && memAddr == SAVE_ADDR));

  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqAck);

  p_ack_follows_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> $past(irqReq, 2));

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memWe && !irqAck));

  p_halt_addr_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (halted && $past(halted)) |-> $stable(memAddr));

endmodule

bind acc_seq_core acc_seq_checker #(
  .ADDR_W    (ADDR_W),
  .SAVE_ADDR (SAVE_ADDR)
) u_acc_seq_checker (
  .clk     (clk),
  .rstN    (rstN),
  .memWe   (memWe),
  .irqAck  (irqAck),
  .irqReq  (irqReq),
  .halted  (halted),
  .memAddr (memAddr)
);

// File: tb/acc_seq_core_bench.sv
module acc_seq_core_bench;

  localparam logic [11:0] START = 12'h010;
  localparam logic [11:0] VEC   = 12'h200;
  localparam logic [11:0] SAVE  = 12'h0FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memRdData;
  logic        irqReq = 1'b0;
  logic [11:0] memAddr;
  logic [15:0] memWrData;
  logic        memWe;
  logic        irqAck;
  logic        halted;

  logic [15:0] mem [0:4095];
  int writeCount;
  int ackCount;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  acc_seq_core #(
    .ADDR_W(12), .START_ADDR(START), .IRQ_VECTOR(VEC), .SAVE_ADDR(SAVE)
  ) u_acc_seq_core (
    .clk(clk), .rstN(rstN), .memRdData(memRdData), .irqReq(irqReq),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe),
    .irqAck(irqAck), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWrData;
    memRdData <= mem[memAddr];
    if (!rstN) begin
      writeCount <= 0;
      ackCount   <= 0;
    end else begin
      if (memWe)  writeCount <= writeCount + 1;
      if (irqAck) ackCount   <= ackCount + 1;
    end
  end

  always @(negedge clk) if (irqAck) irqReq = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic startRun();
    @(negedge clk);
    rstN = 1'b0;
    irqReq = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitHalt(input string req);
    int n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, halted}, 32'd1);
  endtask

  task automatic testReset();
    clearMem();
    mem[START] = 16'h0000;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 memAddr in reset", {20'd0, memAddr}, 32'd0);
    check("R1 memWe in reset", {31'd0, memWe}, 32'd0);
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 irqAck in reset", {31'd0, irqAck}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first fetch address", {20'd0, memAddr}, {20'd0, START});
    waitHalt("R6 zero code halts");
  endtask

  task automatic testLoadAddStore();
    clearMem();
    mem[START]   = 16'h1100;
    mem[START+1] = 16'h5101;
    mem[START+2] = 16'h2102;
    mem[START+3] = 16'h0000;
    mem[12'h100] = 16'h1234;
    mem[12'h101] = 16'h0FED;
    startRun();
    waitHalt("R2 sequential program halts");
    check("R5 add result", {16'd0, mem[12'h102]}, 32'h2221);
    check("R4 single write", writeCount, 32'd1);
  endtask

  task automatic testAddWrap();
    clearMem();
    mem[START]   = 16'h1100;
    mem[START+1] = 16'h5101;
    mem[START+2] = 16'h5101;
    mem[START+3] = 16'h2102;
    mem[START+4] = 16'h0000;
    mem[12'h100] = 16'hFFFF;
    mem[12'h101] = 16'h0003;
    startRun();
    waitHalt("R5 wrap program halts");
    check("R5 modulo add", {16'd0, mem[12'h102]}, 32'h0005);
  endtask

  task automatic testLoadReplaces();
    clearMem();
    mem[START]   = 16'h1100;
    mem[START+1] = 16'h1101;
    mem[START+2] = 16'h2102;
    mem[START+3] = 16'h1100;
    mem[START+4] = 16'h2103;
    mem[START+5] = 16'h0000;
    mem[12'h100] = 16'hAAAA;
    mem[12'h101] = 16'h5A5A;
    startRun();
    waitHalt("R3 load program halts");
    check("R3 second load replaces", {16'd0, mem[12'h102]}, 32'h5A5A);
    check("R3 reload", {16'd0, mem[12'h103]}, 32'hAAAA);
    check("R4 two stores", writeCount, 32'd2);
  endtask

  task automatic testStoreTiming();
    int n = 0;
    clearMem();
    mem[START]   = 16'h2345;
    mem[START+1] = 16'h0000;
    startRun();
    while (!memWe && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R4 store address", {20'd0, memAddr}, 32'h345);
    check("R4 store data is cleared AC", {16'd0, memWrData}, 32'h0000);
    @(negedge clk);
    check("R4 strobe one cycle", {31'd0, memWe}, 32'd0);
    waitHalt("R4 store program halts");
  endtask

  task automatic testHaltIgnores();
    logic [11:0] frozen;
    clearMem();
    mem[START]   = 16'h1100;
    mem[START+1] = 16'h3000;
    mem[START+2] = 16'h2102;
    mem[12'h100] = 16'h7777;
    startRun();
    waitHalt("R6 unlisted code halts");
    frozen = memAddr;
    irqReq = 1'b1;
    repeat (30) @(negedge clk);
    check("R6 no store after halt", {16'd0, mem[12'h102]}, 32'h0000);
    check("R6 no writes", writeCount, 32'd0);
    check("R8 no ack while halted", ackCount, 32'd0);
    check("R8 save slot untouched", {16'd0, mem[SAVE]}, 32'h0000);
    check("R6 address frozen", {20'd0, memAddr}, {20'd0, frozen});
    check("R6 still halted", {31'd0, halted}, 32'd1);
    irqReq = 1'b0;
  endtask

  task automatic testInterrupt();
    clearMem();
    mem[START]   = 16'h1100;
    mem[START+1] = 16'h2102;
    mem[START+2] = 16'h0000;
    mem[VEC]     = 16'h2103;
    mem[VEC+1]   = 16'h0000;
    mem[12'h100] = 16'hBEEF;
    startRun();
    irqReq = 1'b1;
    waitHalt("R7 vector routine halts");
    check("R7 saved return address", {16'd0, mem[SAVE]}, {20'd0, START + 12'd1});
    check("R7 vector ran store", {16'd0, mem[12'h103]}, 32'hBEEF);
    check("R7 skipped instruction not run", {16'd0, mem[12'h102]}, 32'h0000);
    check("R7 one acknowledge", ackCount, 32'd1);
  endtask

  task automatic testStoreWithIrq();
    int n = 0;
    clearMem();
    mem[START]   = 16'h1100;
    mem[START+1] = 16'h2102;
    mem[START+2] = 16'h0000;
    mem[VEC]     = 16'h2103;
    mem[VEC+1]   = 16'h0000;
    mem[12'h100] = 16'h4321;
    startRun();
    while (!memWe && n < 100) begin
      @(negedge clk);
      n++;
    end
    irqReq = 1'b1;
    waitHalt("R7 store plus interrupt halts");
    check("R4 store landed", {16'd0, mem[12'h102]}, 32'h4321);
    check("R7 return after store", {16'd0, mem[SAVE]}, {20'd0, START + 12'd2});
    check("R7 vector store", {16'd0, mem[12'h103]}, 32'h4321);
    check("R9 write count", writeCount, 32'd3);
  endtask

  initial begin
    #(150000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testLoadAddStore();
    testAddWrap();
    testLoadReplaces();
    testStoreTiming();
    testHaltIgnores();
    testInterrupt();
    testStoreWithIrq();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule